// File: doc/BRIEF.md
# Free-Running Interval Timer Compare

This block gives one processor a cycle-accurate time base and a one-shot alarm. A counter starts at zero after reset and advances by one on every clock. Software programs an alarm by writing a target value to the same word address it reads the time from. A read there always returns the running count. A write there loads only the compare register and never disturbs the counter.

The alarm test is plain equality between the compare register and the low `CMP_W` bits of the counter. No magnitude test is made. A target that the counter has already passed therefore fires only once the low bits wrap around. A hit sets a sticky pending flag, which holds until software acknowledges it through a control word. The interrupt line is that flag gated by an enable bit. Each instance is independent, and several instances on one chip are not aligned to one another.

The control word sits at word address 1. On a read, bit 0 is the enable and bit 1 is the pending flag. On a write, bit 0 sets the enable and a one in bit 1 acknowledges the pending flag. Word addresses 2 and 3 are unused.

Top module: `cyc_timer_cmp`

## Requirements
- R1: The counter is cleared by reset and then grows by exactly one on every clock cycle; the first cycle after reset shows 0.
- R2: With `bus_addr` = 0, `bus_rdata` shows the counter in the same cycle, never the compare value.
- R3: A write at word address 0 loads bits `CMP_W-1:0` of `bus_wdata` into the compare register at the next edge and leaves the counter stepping as before.
- R4: When the low `CMP_W` counter bits equal the compare value in a cycle, the pending flag is set from the next cycle on, whatever the upper counter bits or the upper write-data bits are.
- R5: A compare value loaded equal to the counter's low bits in the write cycle itself is missed and fires only after the low bits wrap, 2^`CMP_W` cycles later.
- R6: The pending flag stays set until a write at address 1 with bit 1 set; a control write with bit 1 clear leaves it set.
- R7: If a hit and an acknowledge fall in the same cycle, the pending flag is left set.
- R8: `irq` is high exactly when pending and enable are both set; a control write loads the enable from bit 0; with the enable clear, the pending flag is still readable as bit 1 of address 1.
- R9: Loading a new compare value does not clear a pending flag that is already set.
- R10: Reset clears the counter, the compare register, the pending flag and the enable; since the compare resets to 0, the first post-reset cycle (count 0) is a hit.
- R11: Reads at word addresses 2 and 3 return zero, and writes there change neither the control state nor the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 time/compare, 1 control |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Maskable interrupt request |

## Verification
The embedded properties assume that `rst` is asserted from time zero and that `bus_addr`, `bus_valid` and `bus_write` always carry known values. They also assume at most one register operation per cycle, since the port carries a single access. The bench drives the bus only just after a rising edge and leaves it idle at address 0 between accesses, so the count can be read in every cycle without side effects. The bench uses a narrow compare width (12 bits under a 24-bit counter), so that the wrap-around of an already-passed target and the indifference to the upper counter bits both show up within a few thousand cycles.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    typedef enum logic [1:0] {
        REG_TIME = 2'd0,
        REG_CTRL = 2'd1,
        REG_UNU2 = 2'd2,
        REG_UNU3 = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_PEND_BIT = 1;

    typedef struct packed {
        logic     valid;
        logic     write;
        reg_sel_e sel;
    } bus_op_t;

    typedef struct packed {
        logic load_cmp;
        logic ctrl_wr;
        logic en_val;
        logic ack;
    } reg_cmd_t;

    function automatic reg_cmd_t decode_op(bus_op_t op, logic en_bit, logic ack_bit);
        reg_cmd_t cmd;
        cmd = '0;
        if (op.valid && op.write) begin
            case (op.sel)
                REG_TIME: cmd.load_cmp = 1'b1;
                REG_CTRL: begin
                    cmd.ctrl_wr = 1'b1;
                    cmd.en_val  = en_bit;
                    cmd.ack     = ack_bit;
                end
                default: cmd = '0;
            endcase
        end
        return cmd;
    endfunction

endpackage

// File: rtl/cyc_timer_counter.sv
module cyc_timer_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + CNT_W'(1);
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + CNT_W'(1));

endmodule

// File: rtl/cyc_timer_match.sv
module cyc_timer_match #(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CMP_W-1:0] load_val,
    input  logic [CMP_W-1:0] count_low,
    output logic             hit
);

    logic [CMP_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst)       cmp_q <= '0;
        else if (load) cmp_q <= load_val;
    end

    assign hit = (count_low == cmp_q);

    assert_cmp_load_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> cmp_q == $past(load_val));

endmodule

// File: rtl/cyc_timer_irq_state.sv
module cyc_timer_irq_state (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic ctrl_wr,
    input  logic en_val,
    input  logic ack,
    input  logic cmp_wr,
    output logic en,
    output logic pend,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (ctrl_wr) en <= en_val;
            if (hit)      pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end

    assign irq = pend & en;

    assert_hit_sets_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        pend && !ack |=> pend);

    assert_hit_beats_ack_R7: assert property (@(posedge clk) disable iff (rst)
        hit && ack |=> pend);

    assert_enable_load_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> en == $past(en_val));

    assert_cmp_keeps_pend_R9: assert property (@(posedge clk) disable iff (rst)
        pend && cmp_wr |=> pend);

endmodule

// File: rtl/cyc_timer_cmp.sv
module cyc_timer_cmp #(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    import cyc_timer_pkg::*;

    localparam int LOW_W = (CMP_W < CNT_W) ? CMP_W : CNT_W;

    bus_op_t          op;
    reg_cmd_t         cmd;
    logic [CNT_W-1:0] count;
    logic             hit;
    logic             en;
    logic             pend;
    logic [LOW_W-1:0] load_val;
    logic [LOW_W-1:0] count_low;

    assign op.valid  = bus_valid;
    assign op.write  = bus_write;
    assign op.sel    = reg_sel_e'(bus_addr);
    assign cmd       = decode_op(op, bus_wdata[CTRL_EN_BIT], bus_wdata[CTRL_PEND_BIT]);
    assign load_val  = bus_wdata[LOW_W-1:0];
    assign count_low = count[LOW_W-1:0];

    cyc_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    cyc_timer_match #(.CMP_W(LOW_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd.load_cmp),
        .load_val  (load_val),
        .count_low (count_low),
        .hit       (hit)
    );

    cyc_timer_irq_state u_irq (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .ctrl_wr (cmd.ctrl_wr),
        .en_val  (cmd.en_val),
        .ack     (cmd.ack),
        .cmp_wr  (cmd.load_cmp),
        .en      (en),
        .pend    (pend),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (op.sel)
            REG_TIME: bus_rdata = count;
            REG_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = en;
                bus_rdata[CTRL_PEND_BIT] = pend;
            end
            default: bus_rdata = '0;
        endcase
    end

    assert_mask_R8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq);

    assert_unused_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        bus_addr[1] |-> bus_rdata == '0);

endmodule

// File: tb/test_cyc_timer_cmp.sv
module test_cyc_timer_cmp;

    localparam int CNT_W = 24;
    localparam int CMP_W = 12;
    localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'((1 << CMP_W) - 1);
    localparam int VEC_N = 6;
    localparam int          VEC_DELTA [VEC_N] = '{1, 2, 3, 9, 64, 700};
    localparam logic [11:0] VEC_HIGH  [VEC_N] = '{12'h000, 12'hABC, 12'h5A5, 12'hFFF, 12'h123, 12'h001};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic             irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cyc_timer_cmp #(.CNT_W(CNT_W), .CMP_W(CMP_W)) i_cyc_timer_cmp (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(posedge clk);
        #1;
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 2'd0, '0);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1; bus_valid = 1'b0; bus_addr = 2'd0;
        @(posedge clk);
        @(negedge clk);
        check(bus_rdata == 0, "R10 count in reset", bus_rdata, 0);
        check(irq == 1'b0, "R10 irq in reset", irq, 0);
        @(posedge clk); #1; bus_addr = 2'd1;
        @(negedge clk);
        check(bus_rdata == 0, "R10 control in reset", bus_rdata, 0);
        @(posedge clk); #1; rst = 1'b0; bus_addr = 2'd0;
        @(negedge clk);
        check(bus_rdata == 0, "R1 first count", bus_rdata, 0);
        @(posedge clk); #1; bus_addr = 2'd1;
        @(negedge clk);
        check(bus_rdata == 2, "R10 zero compare hits count 0", bus_rdata, 2);
        @(posedge clk); #1; bus_addr = 2'd0;
        @(negedge clk);
        check(bus_rdata == 2, "R1 count after two cycles", bus_rdata, 2);
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] c0;
        logic [CNT_W-1:0] c;
        logic [CNT_W-1:0] tgt;
        int early;

        do_reset();

        // Vector table: program a target d cycles ahead, expect irq exactly d+1 samples later
        for (int v = 0; v < VEC_N; v++) begin
            idle();
            c0 = bus_rdata;
            drive(1'b1, 1'b1, 2'd1, CNT_W'(3));
            c   = c0 + CNT_W'(2);
            tgt = (c + CNT_W'(VEC_DELTA[v])) & LOW_MASK;
            drive(1'b1, 1'b1, 2'd0, {VEC_HIGH[v], tgt[11:0]});
            check(bus_rdata == c, "R1 R2 count during compare write", bus_rdata, c);
            early = 0;
            for (int j = 1; j <= VEC_DELTA[v] + 1; j++) begin
                idle();
                if (j <= VEC_DELTA[v] && irq) early++;
                if (j == VEC_DELTA[v] + 1) begin
                    check(irq == 1'b1, "R4 fires after hit", irq, 1);
                    check(bus_rdata == c + CNT_W'(j), "R3 counter undisturbed", bus_rdata, c + CNT_W'(j));
                end
            end
            check(early == 0, "R4 no early fire", early, 0);
        end

        // R8: mask with pending set
        drive(1'b1, 1'b1, 2'd1, CNT_W'(0));
        idle();
        check(irq == 1'b0, "R8 masked irq", irq, 0);
        drive(1'b0, 1'b0, 2'd1, '0);
        check(bus_rdata == 2, "R8 pending visible while masked", bus_rdata, 2);
        // R6: control write without ack keeps pending
        drive(1'b1, 1'b1, 2'd1, CNT_W'(1));
        idle();
        check(irq == 1'b1, "R6 R8 unmask keeps pending", irq, 1);
        // R9: new compare leaves pending
        c0 = bus_rdata;
        drive(1'b1, 1'b1, 2'd0, (c0 + CNT_W'(2000)) & LOW_MASK);
        idle();
        check(irq == 1'b1, "R9 compare write keeps pending", irq, 1);
        // R6: acknowledge clears
        drive(1'b1, 1'b1, 2'd1, CNT_W'(3));
        idle();
        check(irq == 1'b0, "R6 ack clears", irq, 0);

        // R11: unused addresses
        drive(1'b1, 1'b1, 2'd2, '1);
        drive(1'b1, 1'b1, 2'd3, '1);
        drive(1'b0, 1'b0, 2'd2, '0);
        check(bus_rdata == 0, "R11 addr2 reads zero", bus_rdata, 0);
        drive(1'b0, 1'b0, 2'd3, '0);
        check(bus_rdata == 0, "R11 addr3 reads zero", bus_rdata, 0);
        drive(1'b0, 1'b0, 2'd1, '0);
        check(bus_rdata == 1, "R11 control unchanged", bus_rdata, 1);

        // R7: hit and ack in the same cycle
        idle();
        c0 = bus_rdata;
        drive(1'b1, 1'b1, 2'd0, (c0 + CNT_W'(3)) & LOW_MASK);
        idle();
        check(irq == 1'b0, "R7 clear before hit", irq, 0);
        drive(1'b1, 1'b1, 2'd1, CNT_W'(3));
        idle();
        check(irq == 1'b1, "R7 hit wins over ack", irq, 1);
        drive(1'b1, 1'b1, 2'd1, CNT_W'(3));
        idle();
        check(irq == 1'b0, "R6 ack after R7", irq, 0);

        // R5: target equal to count in the write cycle fires only after wrap
        idle();
        c0 = bus_rdata;
        drive(1'b1, 1'b1, 2'd0, (c0 + CNT_W'(1)) & LOW_MASK);
        early = 0;
        for (int j = 1; j <= (1 << CMP_W) + 1; j++) begin
            idle();
            if (j <= (1 << CMP_W) && irq) early++;
            if (j == (1 << CMP_W)) check(irq == 1'b0, "R5 not yet at wrap cycle", irq, 0);
            if (j == (1 << CMP_W) + 1) check(irq == 1'b1, "R5 R4 fires after wrap", irq, 1);
        end
        check(early == 0, "R5 passed target silent until wrap", early, 0);

        // R10: reset while irq is active
        do_reset();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule